// File: doc/BRIEF.md
# Lockable GPIO Register Bank

This block is the software-visible configuration store of a 32-pin general-purpose I/O port. A word-addressed bus with separate read and write strobes reaches a 4 KiB window. Inside it sit the registers that decide pin direction, driven level, drive type, pull resistors, input masking and event configuration. Their current values are presented as parallel outputs to the neighbouring pin-resolution and event-detection blocks. The sampled input word and the per-pin event hits come back in from those neighbours. The bank keeps the sticky event status, which software clears by writing ones.

Three registers (output data, output enable and event enable) each have a set alias and a clear alias. Software can therefore change individual bits with one write and no read-modify-write. A global lock guards all of this. Writing either lock word while the bank is open closes it. Once closed, the bank accepts writes only to the two lock words. It reopens only after a two-step key sequence. Every illegal access raises a one-cycle error pulse. Illegal accesses are: an unmapped or misaligned offset, a read of a write-only word, a write to the read-only input word, and a write to a frozen register.

Top module: `gpio_lock_bank`

## Requirements
- R1: After reset every register reads zero, except pull-up (0x1C), pull-down (0x20), slew (0x5C) and drive strength (0x60), which take the reset-value parameters. The configuration outputs show the same values.
- R2: While open, a write to a read/write register (polarity 0x08, output data 0x0C, output enable 0x10, open-drain 0x14, pull-up 0x1C, pull-down 0x20, event type 0x28, both-edge 0x2C, event enable 0x40, input mask 0x58, slew 0x5C, drive 0x60) stores the full word. Read data appears on `bus_rdata_o` in the cycle after the read strobe.
- R3: While open, a write of any value to lock word A (0x00) or lock word B (0x7C) closes the bank. After that, 0x00 reads 1 and lock word B holds zero.
- R4: While closed, writes to any offset other than 0x00 and 0x7C leave every register and output unchanged, and raise the error pulse.
- R5: While closed, a write of 0xC0DEFA73 to 0x00 opens the bank only if lock word B already holds 0xC0DE1248. A write to 0x7C stores its value. Opening clears lock word B, so after a relock the A key alone does not open the bank.
- R6: A write to 0x68 or 0x70 ORs the value into output data or output enable. A write to 0x6C or 0x74 clears the bits that are 1 in the value.
- R7: A write to 0x44 ORs the value into event enable, and a write to 0x48 clears the bits that are 1 in the value.
- R8: 0x04 reads the sampled input word `pin_in_i`. A write to 0x04 is dropped and raises the error pulse.
- R9: The write-only words (0x44, 0x48, 0x68, 0x6C, 0x70, 0x74, 0x7C) read zero and raise the error pulse.
- R10: Event status (0x4C) sets each bit whose `evt_hit_i` bit is 1. A write clears the status bits that are 1 in the value. If a hit and a clear land on the same bit in the same cycle, the hit wins.
- R11: An access to an unmapped offset (0x64, 0x78, anything at or above 0x80) or to an address with bits [1:0] not zero reads zero, changes nothing and raises the error pulse.
- R12: The mode (0x18), debounce (0x24) and four blink words (0x30 to 0x3C) store and read back their values without acting on pins. The two per-pin lock words (0x50, 0x54) accept writes without storing them and read zero, with no error.
- R13: `bus_err_o` is high for exactly the cycle after an illegal access and low after every legal access or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 12 | Byte address in the window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| bus_err_o | output | 1 | One-cycle illegal-access pulse |
| pin_in_i | input | 32 | Sampled input word from pin resolution |
| evt_hit_i | input | 32 | Per-pin event hits from event detection |
| pol_o | output | 32 | Polarity inversion |
| dout_o | output | 32 | Output data |
| oe_o | output | 32 | Output enable |
| odrain_o | output | 32 | Open-drain select |
| pullup_o | output | 32 | Pull-up enable |
| pulldn_o | output | 32 | Pull-down enable |
| evt_type_o | output | 32 | Event type (edge/level) |
| evt_both_o | output | 32 | Both-edge select |
| evt_en_o | output | 32 | Event enable |
| in_mask_o | output | 32 | Input enable mask |
| slew_o | output | 32 | Slew-rate select |
| drive_o | output | 32 | Drive-strength select |
| evt_status_o | output | 32 | Sticky event status |

## Verification
The bench builds the bank with four distinct non-zero reset patterns: 0x000000F0 for pull-up, 0x0F000000 for pull-down, 0xA5A50000 for slew and 0x00005A5A for drive. A reset-value mix-up between these registers, or a load of zero, therefore becomes visible on both the bus and the ports. Set and clear patterns are chosen to overlap existing bits, so an alias that overwrites instead of merging shows up. The lock is walked through the wrong-order, wrong-key, correct and relock-with-stale-key cases.

// File: rtl/gpio_lock_bank_pkg.sv
package gpio_lock_bank_pkg;

  // Word selects: values 1..25 follow the word index 0..24 of the window.
  typedef enum logic [4:0] {
    SEL_NONE, SEL_LOCKA, SEL_DIN, SEL_POL, SEL_DOUT, SEL_OE, SEL_ODRN,
    SEL_MODE, SEL_PU, SEL_PD, SEL_DBNC, SEL_EVTYP, SEL_EVBOTH,
    SEL_BL0, SEL_BL1, SEL_BL2, SEL_BL3, SEL_EVEN, SEL_EVEN_S, SEL_EVEN_C,
    SEL_EVST, SEL_PLK0, SEL_PLK1, SEL_IMASK, SEL_SLEW, SEL_DRV,
    SEL_DOUT_S, SEL_DOUT_C, SEL_OE_S, SEL_OE_C, SEL_LOCKB
  } sel_e;

  localparam logic [31:0] KEY_A = 32'hC0DE_FA73;
  localparam logic [31:0] KEY_B = 32'hC0DE_1248;

  localparam int NPLAIN = 15;
  localparam int P_POL = 0, P_ODRN = 1, P_MODE = 2, P_PU = 3, P_PD = 4;
  localparam int P_DBNC = 5, P_EVTYP = 6, P_EVBOTH = 7, P_IMASK = 12;
  localparam int P_SLEW = 13, P_DRV = 14;

  localparam int NSC = 3;
  localparam int SC_DOUT = 0, SC_OE = 1, SC_EVEN = 2;

  function automatic sel_e plain_sel(int i);
    case (i)
      0: return SEL_POL;    1: return SEL_ODRN;   2: return SEL_MODE;
      3: return SEL_PU;     4: return SEL_PD;     5: return SEL_DBNC;
      6: return SEL_EVTYP;  7: return SEL_EVBOTH; 8: return SEL_BL0;
      9: return SEL_BL1;    10: return SEL_BL2;   11: return SEL_BL3;
      12: return SEL_IMASK; 13: return SEL_SLEW;  default: return SEL_DRV;
    endcase
  endfunction

  // kind 0 = full word, 1 = set alias, 2 = clear alias
  function automatic sel_e sc_sel(int k, int kind);
    case (k)
      0: return (kind == 0) ? SEL_DOUT : (kind == 1) ? SEL_DOUT_S : SEL_DOUT_C;
      1: return (kind == 0) ? SEL_OE : (kind == 1) ? SEL_OE_S : SEL_OE_C;
      default: return (kind == 0) ? SEL_EVEN : (kind == 1) ? SEL_EVEN_S : SEL_EVEN_C;
    endcase
  endfunction

  function automatic logic is_wonly(sel_e s);
    return (s == SEL_EVEN_S) || (s == SEL_EVEN_C) || (s == SEL_DOUT_S) ||
           (s == SEL_DOUT_C) || (s == SEL_OE_S) || (s == SEL_OE_C) ||
           (s == SEL_LOCKB);
  endfunction

endpackage

// File: rtl/gpio_lock_bank_decode.sv
module gpio_lock_bank_decode
  import gpio_lock_bank_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_e              sel_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             low_win;

  assign idx     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);
  assign low_win = ((idx >> 5) == '0);

  always_comb begin
    sel_o = SEL_NONE;
    if (aligned && low_win) begin
      if (idx[4:0] <= 5'd24) begin
        sel_o = sel_e'(5'(idx[4:0] + 5'd1));
      end else begin
        case (idx[4:0])
          5'd26:   sel_o = SEL_DOUT_S;
          5'd27:   sel_o = SEL_DOUT_C;
          5'd28:   sel_o = SEL_OE_S;
          5'd29:   sel_o = SEL_OE_C;
          5'd31:   sel_o = SEL_LOCKB;
          default: sel_o = SEL_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_lock_bank_lock.sv
module gpio_lock_bank_lock
  import gpio_lock_bank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_a_i,
  input  logic              wr_b_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              locked_o
);
  logic              locked_q, locked_d;
  logic [DATA_W-1:0] keyb_q, keyb_d;
  logic              en;

  assign en = wr_a_i | wr_b_i;

  always_comb begin
    locked_d = locked_q;
    keyb_d   = keyb_q;
    if (!locked_q) begin
      locked_d = 1'b1;
      keyb_d   = '0;
    end else if (wr_b_i) begin
      keyb_d = wdata_i;
    end else if (keyb_q == DATA_W'(KEY_B) && wdata_i == DATA_W'(KEY_A)) begin
      locked_d = 1'b0;
      keyb_d   = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      keyb_q   <= '0;
    end else if (en) begin
      locked_q <= locked_d;
      keyb_q   <= keyb_d;
    end
  end

  assign locked_o = locked_q;

  AST_LOCK_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && (wr_a_i || wr_b_i)) |=> locked_q); // R3
  AST_ONLY_A_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_q && !wr_a_i) |=> locked_q); // R5
  AST_OPEN_NEEDS_KEYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> ($past(keyb_q) == DATA_W'(KEY_B) &&
                         $past(wdata_i) == DATA_W'(KEY_A))); // R5
endmodule

// File: rtl/gpio_lock_bank_screg.sv
module gpio_lock_bank_screg #(
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_full_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q, q_d;
  logic              en;

  assign en = wr_full_i | wr_set_i | wr_clr_i;

  always_comb begin
    q_d = q_q;
    if (wr_full_i)     q_d = wdata_i;
    else if (wr_set_i) q_d = q_q | wdata_i;
    else if (wr_clr_i) q_d = q_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  q_q <= RST_VAL;
    else if (en)  q_q <= q_d;
  end

  assign q_o = q_q;

  AST_SET_MERGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((q_q & $past(wdata_i)) == $past(wdata_i))); // R6
  AST_CLR_MERGES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((q_q & $past(wdata_i)) == '0)); // R6
endmodule

// File: rtl/gpio_lock_bank.sv
module gpio_lock_bank
  import gpio_lock_bank_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter logic [31:0] RST_PULLUP = 32'h0,
  parameter logic [31:0] RST_PULLDN = 32'h0,
  parameter logic [31:0] RST_SLEW   = 32'h0,
  parameter logic [31:0] RST_DRIVE  = 32'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_err_o,
  input  logic [DATA_W-1:0] pin_in_i,
  input  logic [DATA_W-1:0] evt_hit_i,
  output logic [DATA_W-1:0] pol_o,
  output logic [DATA_W-1:0] dout_o,
  output logic [DATA_W-1:0] oe_o,
  output logic [DATA_W-1:0] odrain_o,
  output logic [DATA_W-1:0] pullup_o,
  output logic [DATA_W-1:0] pulldn_o,
  output logic [DATA_W-1:0] evt_type_o,
  output logic [DATA_W-1:0] evt_both_o,
  output logic [DATA_W-1:0] evt_en_o,
  output logic [DATA_W-1:0] in_mask_o,
  output logic [DATA_W-1:0] slew_o,
  output logic [DATA_W-1:0] drive_o,
  output logic [DATA_W-1:0] evt_status_o
);
  sel_e              sel;
  logic              locked;
  logic              wr_ok;
  logic              illegal;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] plain_q [NPLAIN];
  logic [DATA_W-1:0] sc_q    [NSC];
  logic [DATA_W-1:0] evst_q, evst_d;
  logic              evst_clr;
  logic [DATA_W-1:0] rdata_q;
  logic              err_q;

  gpio_lock_bank_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  gpio_lock_bank_lock #(.DATA_W(DATA_W)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_a_i   (bus_wr_i && sel == SEL_LOCKA),
    .wr_b_i   (bus_wr_i && sel == SEL_LOCKB),
    .wdata_i  (bus_wdata_i),
    .locked_o (locked)
  );

  assign wr_ok = bus_wr_i & ~locked;

  // Plain storage registers
  for (genvar i = 0; i < NPLAIN; i++) begin : g_plain
    localparam logic [DATA_W-1:0] RV =
      (i == P_PU)   ? DATA_W'(RST_PULLUP) :
      (i == P_PD)   ? DATA_W'(RST_PULLDN) :
      (i == P_SLEW) ? DATA_W'(RST_SLEW)   :
      (i == P_DRV)  ? DATA_W'(RST_DRIVE)  : '0;
    logic we;
    assign we = wr_ok && (sel == plain_sel(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  plain_q[i] <= RV;
      else if (we)  plain_q[i] <= bus_wdata_i;
    end
  end

  // Registers with set / clear aliases
  for (genvar k = 0; k < NSC; k++) begin : g_sc
    gpio_lock_bank_screg #(.DATA_W(DATA_W), .RST_VAL('0)) u_reg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_full_i (wr_ok && sel == sc_sel(k, 0)),
      .wr_set_i  (wr_ok && sel == sc_sel(k, 1)),
      .wr_clr_i  (wr_ok && sel == sc_sel(k, 2)),
      .wdata_i   (bus_wdata_i),
      .q_o       (sc_q[k])
    );
  end

  // Sticky event status, write-one-to-clear, hit wins
  assign evst_clr = wr_ok && (sel == SEL_EVST);

  always_comb begin
    evst_d = evst_q;
    if (evst_clr) evst_d = evst_d & ~bus_wdata_i;
    evst_d = evst_d | evt_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evst_q <= '0;
    else         evst_q <= evst_d;
  end

  // Legality
  always_comb begin
    illegal = 1'b0;
    if (bus_rd_i && (sel == SEL_NONE || is_wonly(sel))) illegal = 1'b1;
    if (bus_wr_i && (sel == SEL_NONE || sel == SEL_DIN)) illegal = 1'b1;
    if (bus_wr_i && locked && sel != SEL_LOCKA && sel != SEL_LOCKB) illegal = 1'b1;
  end

  // Read mux
  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_LOCKA: rd_mux = DATA_W'(locked);
      SEL_DIN:   rd_mux = pin_in_i;
      SEL_DOUT:  rd_mux = sc_q[SC_DOUT];
      SEL_OE:    rd_mux = sc_q[SC_OE];
      SEL_EVEN:  rd_mux = sc_q[SC_EVEN];
      SEL_EVST:  rd_mux = evst_q;
      default: begin
        for (int i = 0; i < NPLAIN; i++) begin
          if (sel == plain_sel(i)) rd_mux = plain_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= illegal;
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_err_o    = err_q;
  assign pol_o        = plain_q[P_POL];
  assign odrain_o     = plain_q[P_ODRN];
  assign pullup_o     = plain_q[P_PU];
  assign pulldn_o     = plain_q[P_PD];
  assign evt_type_o   = plain_q[P_EVTYP];
  assign evt_both_o   = plain_q[P_EVBOTH];
  assign in_mask_o    = plain_q[P_IMASK];
  assign slew_o       = plain_q[P_SLEW];
  assign drive_o      = plain_q[P_DRV];
  assign dout_o       = sc_q[SC_DOUT];
  assign oe_o         = sc_q[SC_OE];
  assign evt_en_o     = sc_q[SC_EVEN];
  assign evt_status_o = evst_q;

  AST_LOCKED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> ($stable(dout_o) && $stable(oe_o) && $stable(evt_en_o) &&
                $stable(pol_o) && $stable(pullup_o))); // R4
  AST_HIT_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_hit_i != '0) |=> ((evt_status_o & $past(evt_hit_i)) == $past(evt_hit_i))); // R10
  AST_NO_CLEAR_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && !locked) |=> ((evt_status_o & $past(evt_status_o)) == $past(evt_status_o))); // R10
endmodule

// File: tb/tb_gpio_lock_bank.sv
module tb_gpio_lock_bank;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] PU  = 32'h0000_00F0;
  localparam logic [31:0] PD  = 32'h0F00_0000;
  localparam logic [31:0] SLW = 32'hA5A5_0000;
  localparam logic [31:0] DRV = 32'h0000_5A5A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr, rd;
  logic [11:0] addr;
  logic [31:0] wdata, rdata, pin_in, hit;
  logic        err;
  logic [31:0] pol, dout, oe, odrn, pup, pdn, etyp, eboth, een, imask, slew, drive, evst;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_lock_bank #(
    .ADDR_W(12), .DATA_W(32),
    .RST_PULLUP(PU), .RST_PULLDN(PD), .RST_SLEW(SLW), .RST_DRIVE(DRV)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err),
    .pin_in_i(pin_in), .evt_hit_i(hit),
    .pol_o(pol), .dout_o(dout), .oe_o(oe), .odrain_o(odrn), .pullup_o(pup),
    .pulldn_o(pdn), .evt_type_o(etyp), .evt_both_o(eboth), .evt_en_o(een),
    .in_mask_o(imask), .slew_o(slew), .drive_o(drive), .evt_status_o(evst)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    bit          eerr;
    string       tag;
    int          due;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: called at a negedge, returns at the next negedge.
  task automatic op(bit w, bit r, logic [11:0] a, logic [31:0] d, logic [31:0] h,
                    logic [31:0] exp, bit eerr, string tag);
    item_t it;
    wr = w; rd = r; addr = a; wdata = d; hit = h;
    it.is_rd = r; it.exp = exp; it.eerr = eerr; it.tag = tag; it.due = cyc + 1;
    q.push_back(it);
    @(negedge clk);
    wr = 0; rd = 0; hit = '0;
  endtask

  task automatic wr_op(logic [11:0] a, logic [31:0] d, bit eerr, string tag);
    op(1, 0, a, d, '0, '0, eerr, tag);
  endtask

  task automatic rd_op(logic [11:0] a, logic [31:0] exp, bit eerr, string tag);
    op(0, 1, a, '0, '0, exp, eerr, tag);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.is_rd) chk({it.tag, " rdata"}, rdata, it.exp);
        chk({it.tag, " err"}, {31'b0, err}, {31'b0, it.eerr});
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr = 0; rd = 0; addr = '0; wdata = '0; hit = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pullup_o", pup, PU);
    chk("R1 pulldn_o", pdn, PD);
    chk("R1 slew_o", slew, SLW);
    chk("R1 drive_o", drive, DRV);
    chk("R1 dout_o", dout, '0);
    chk("R1 evt_status_o", evst, '0);
    rd_op(12'h01C, PU, 0, "R1 pullup read");
    rd_op(12'h060, DRV, 0, "R1 drive read");
    rd_op(12'h000, 32'h0, 0, "R1 lock open");
    rd_op(12'h010, 32'h0, 0, "R1 oe read");

    // R2 plain read/write
    wr_op(12'h008, 32'h1234_5678, 0, "R2 pol write");
    rd_op(12'h008, 32'h1234_5678, 0, "R2 pol read");
    chk("R2 pol_o", pol, 32'h1234_5678);
    wr_op(12'h058, 32'hFFFF_0001, 0, "R2 imask write");
    chk("R2 in_mask_o", imask, 32'hFFFF_0001);
    wr_op(12'h014, 32'h0000_0300, 0, "R2 odrain write");
    rd_op(12'h014, 32'h0000_0300, 0, "R2 odrain read");

    // R6 set / clear aliases
    wr_op(12'h00C, 32'h0000_FF00, 0, "R6 dout write");
    wr_op(12'h068, 32'h0000_010F, 0, "R6 dout set");
    rd_op(12'h00C, 32'h0000_FF0F, 0, "R6 dout after set");
    wr_op(12'h06C, 32'h0000_0F0F, 0, "R6 dout clr");
    rd_op(12'h00C, 32'h0000_F000, 0, "R6 dout after clr");
    chk("R6 dout_o", dout, 32'h0000_F000);
    wr_op(12'h070, 32'h0000_0003, 0, "R6 oe set");
    wr_op(12'h074, 32'h0000_0001, 0, "R6 oe clr");
    rd_op(12'h010, 32'h0000_0002, 0, "R6 oe read");

    // R7 event enable aliases, R9 write-only reads
    wr_op(12'h040, 32'h0000_0010, 0, "R7 even write");
    wr_op(12'h044, 32'h0000_0003, 0, "R7 even set");
    rd_op(12'h040, 32'h0000_0013, 0, "R7 even after set");
    wr_op(12'h048, 32'h0000_0011, 0, "R7 even clr");
    chk("R7 evt_en_o", een, 32'h0000_0002);
    rd_op(12'h044, 32'h0, 1, "R9 even-set read");
    rd_op(12'h06C, 32'h0, 1, "R9 dout-clr read");
    rd_op(12'h07C, 32'h0, 1, "R9 lockB read");

    // R8 data-in
    pin_in = 32'hDEAD_BEEF;
    rd_op(12'h004, 32'hDEAD_BEEF, 0, "R8 din read");
    wr_op(12'h004, 32'h1111_1111, 1, "R8 din write dropped");
    rd_op(12'h004, 32'hDEAD_BEEF, 0, "R8 din unchanged");

    // R10 event status
    op(0, 0, 12'h000, '0, 32'h0000_0005, '0, 0, "R10 hit");
    chk("R10 evt_status_o", evst, 32'h0000_0005);
    wr_op(12'h04C, 32'h0000_0001, 0, "R10 w1c");
    rd_op(12'h04C, 32'h0000_0004, 0, "R10 after w1c");
    op(1, 0, 12'h04C, 32'h0000_0004, 32'h0000_0004, '0, 0, "R10 hit vs clr");
    rd_op(12'h04C, 32'h0000_0004, 0, "R10 hit wins");

    // R11 unmapped / misaligned; R13 err drops after one cycle
    rd_op(12'h064, 32'h0, 1, "R11 read 0x64");
    op(0, 0, 12'h000, '0, '0, '0, 0, "R13 idle after err");
    rd_op(12'h800, 32'h0, 1, "R11 read high");
    wr_op(12'h078, 32'hFFFF_FFFF, 1, "R11 write 0x78");
    rd_op(12'h00D, 32'h0, 1, "R11 misaligned read");
    wr_op(12'h00E, 32'hFFFF_FFFF, 1, "R11 misaligned write");
    rd_op(12'h00C, 32'h0000_F000, 0, "R11 dout untouched");

    // R12 store-only and per-pin lock words
    wr_op(12'h018, 32'h0000_0077, 0, "R12 mode write");
    rd_op(12'h018, 32'h0000_0077, 0, "R12 mode read");
    wr_op(12'h03C, 32'hCAFE_0000, 0, "R12 blink3 write");
    rd_op(12'h03C, 32'hCAFE_0000, 0, "R12 blink3 read");
    wr_op(12'h050, 32'hFFFF_FFFF, 0, "R12 plk write");
    rd_op(12'h050, 32'h0, 0, "R12 plk read");

    // R3 lock via lock word B
    wr_op(12'h07C, 32'h1234_0000, 0, "R3 lock via B");
    rd_op(12'h000, 32'h1, 0, "R3 locked reads 1");

    // R4 writes frozen
    wr_op(12'h00C, 32'hFFFF_FFFF, 1, "R4 dout write locked");
    wr_op(12'h068, 32'hFFFF_FFFF, 1, "R4 dout set locked");
    wr_op(12'h04C, 32'hFFFF_FFFF, 1, "R4 evst w1c locked");
    wr_op(12'h01C, 32'h0, 1, "R4 pullup locked");
    rd_op(12'h00C, 32'h0000_F000, 0, "R4 dout frozen");
    chk("R4 dout_o", dout, 32'h0000_F000);
    chk("R4 pullup_o", pup, PU);
    chk("R4 evt_status_o", evst, 32'h0000_0004);

    // R5 unlock sequence (lock word B cleared by the lock entry)
    wr_op(12'h000, 32'hC0DE_FA73, 0, "R5 A key without B");
    rd_op(12'h000, 32'h1, 0, "R5 still locked");
    wr_op(12'h07C, 32'hC0DE_1248, 0, "R5 B key");
    wr_op(12'h000, 32'h0BAD_0BAD, 0, "R5 wrong A");
    rd_op(12'h000, 32'h1, 0, "R5 wrong A stays locked");
    wr_op(12'h000, 32'hC0DE_FA73, 0, "R5 A key");
    rd_op(12'h000, 32'h0, 0, "R5 opened");
    wr_op(12'h00C, 32'h0000_00AA, 0, "R5 write after open");
    chk("R5 dout_o after open", dout, 32'h0000_00AA);
    wr_op(12'h000, 32'h0, 0, "R5 relock via A");
    wr_op(12'h000, 32'hC0DE_FA73, 0, "R5 stale B");
    rd_op(12'h000, 32'h1, 0, "R5 stale B stays locked");
    op(0, 0, 12'h000, '0, '0, '0, 0, "R13 idle");
    op(0, 0, 12'h000, '0, '0, '0, 0, "R13 idle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule